// File: doc/BRIEF.md
# Reference Divider with Phase-Detector Output Control

This block divides a reference clock by a programmable ratio and drives a digital model of a charge-pump output from the divided reference and an externally supplied feedback-divider pulse. A three-state phase/frequency comparator produces "pump up" and "pump down" requests. A polarity input decides which of these requests becomes up and which becomes down. A high-impedance control can disable the pump, and it also clears the comparator.

A test input replaces the pump signal with a raw counter pulse, so that either divider can be observed on the pump pin. In test mode the polarity input picks the counter. The whole block runs on the reference clock. Every output is registered.

The divided-reference pulse appears one clock after the counter's terminal state. The comparator flags add one more register. The output stage adds a further register. As a result, a reference or feedback event reaches the pump pins two clocks after the cycle in which it is present.

Top module: `refdiv_pd_top`

## Requirements
- R1: While reset is high, and after it, until the first clock with reset low, `ref_pulse_o`, `pump_up_o`, `pump_dn_o` and `pump_oe_o` are all 0.
- R2: `ref_pulse_o` is high for exactly one clock out of every R clocks, for any ratio R from 2 to 1023. The first pulse follows the first clock edge with reset low.
- R3: A ratio input of 0 or 1 is a prohibited setting, and the divider treats it as a ratio of 2.
- R4: The ratio input is sampled only when the counter reloads at its terminal count. A change in the middle of a count does not alter the current period.
- R5: In normal mode (`test_mode_i`=0, `pump_hiz_i`=0, `sense_pos_i`=1), `pump_oe_o` is 1. A divided-reference event that leads a feedback event raises `pump_up_o`, and `pump_up_o` stays high until the feedback event arrives. A feedback event that leads raises `pump_dn_o` in the same way. Coincident events clear both outputs. Up and down are never high together.
- R6: With `sense_pos_i`=0 in normal mode, up and down are swapped. A leading reference event gives `pump_dn_o`, and a leading feedback event gives `pump_up_o`.
- R7: With `pump_hiz_i`=1 and `test_mode_i`=0, `pump_oe_o`, `pump_up_o` and `pump_dn_o` are 0 from the next clock on. The comparator is also held cleared, so no event seen during that time survives it.
- R8: With `test_mode_i`=1, `pump_oe_o` is 1 and `pump_dn_o` is 0. `pump_up_o` copies, one clock later, the feedback pulse when `sense_pos_i`=1 or the divided-reference pulse when `sense_pos_i`=0. This holds whatever the value of `pump_hiz_i`, which is required to be 1 in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio_i | input | CNT_W (10) | Reference divide ratio |
| sense_pos_i | input | 1 | 1: positive sense / feedback observed in test mode; 0: negative sense / reference observed |
| pump_hiz_i | input | 1 | 1: pump output high impedance and comparator cleared |
| test_mode_i | input | 1 | 1: a counter pulse is routed to the pump output |
| n_pulse_i | input | 1 | One-cycle pulse from the feedback divider |
| ref_pulse_o | output | 1 | One-cycle divided-reference pulse |
| pump_up_o | output | 1 | Pump up request, or the observed counter pulse in test mode |
| pump_dn_o | output | 1 | Pump down request |
| pump_oe_o | output | 1 | Pump output enable (0 = high impedance) |

## Verification
The assertions check the following on every cycle:
- the divided-reference pulse never lasts two cycles;
- the comparator flags, and the up and down outputs, are mutually exclusive;
- the high-impedance setting blanks the output and clears the comparator on the next clock;
- test mode routes the selected counter pulse and keeps down low.

Some behaviours appear only in the bench's scenarios, where a behavioural model is compared against the block on every clock:
- the exact period at each ratio, including the clamping of 0 and 1 and the largest ratio;
- the deferral of a ratio change to the next terminal count;
- the lead, lag and coincident cases of the comparator under both polarities.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  // Comparator state: pending up or down request.
  typedef struct packed {
    logic up;
    logic dn;
  } phase_t;

  // Registered pump-pin model.
  typedef struct packed {
    logic up;
    logic dn;
    logic oe;
  } pump_t;
endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CNT_W     = 10,
  parameter int MIN_RATIO = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_RATIO);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ratio_eff;
  logic             term;

  // Prohibited small ratios fall back to the minimum.
  always_comb begin
    ratio_eff = (ratio_i < MIN_V) ? MIN_V : ratio_i;
    term      = (cnt_q == '0);
  end

  // The ratio is only sampled on reload, so mid-count changes wait.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (term) begin
      cnt_q   <= ratio_eff - ONE_V;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - ONE_V;
      pulse_o <= 1'b0;
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  assert_reload_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (cnt_q >= MIN_V - ONE_V));
endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ref_ev_i,
  input  logic   n_ev_i,
  input  logic   clear_i,
  output phase_t flags_o
);
  logic set_up, set_dn;

  always_comb begin
    set_up = flags_o.up | ref_ev_i;
    set_dn = flags_o.dn | n_ev_i;
  end

  // Three-state comparator: both requests present resets the pair.
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      flags_o <= '0;
    end else if (set_up && set_dn) begin
      flags_o <= '0;
    end else begin
      flags_o.up <= set_up;
      flags_o.dn <= set_dn;
    end
  end

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(flags_o.up && flags_o.dn));

  assert_clear_holds_R7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (flags_o == '0));

  assert_coincident_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (ref_ev_i && n_ev_i) |=> (flags_o == '0));
endmodule

// File: rtl/refdiv_outmux.sv
module refdiv_outmux
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t flags_i,
  input  logic   ref_ev_i,
  input  logic   n_ev_i,
  input  logic   test_i,
  input  logic   pos_i,
  input  logic   hiz_i,
  output pump_t  pump_o
);
  pump_t pump_d;

  always_comb begin
    if (test_i) begin
      // Observation path: the polarity control picks the counter.
      pump_d.up = pos_i ? n_ev_i : ref_ev_i;
      pump_d.dn = 1'b0;
      pump_d.oe = 1'b1;
    end else if (hiz_i) begin
      pump_d = '0;
    end else begin
      pump_d.up = pos_i ? flags_i.up : flags_i.dn;
      pump_d.dn = pos_i ? flags_i.dn : flags_i.up;
      pump_d.oe = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pump_o <= '0;
    else     pump_o <= pump_d;
  end

  assert_hiz_blank_R7: assert property (@(posedge clk) disable iff (rst)
    (hiz_i && !test_i) |=> (pump_o == '0));

  assert_test_select_R8: assert property (@(posedge clk) disable iff (rst)
    test_i |=> (pump_o.oe && !pump_o.dn &&
                (pump_o.up == ($past(pos_i) ? $past(n_ev_i) : $past(ref_ev_i)))));

  assert_up_dn_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(pump_o.up && pump_o.dn));

  assert_drive_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    (!hiz_i && !test_i) |=> pump_o.oe);
endmodule

// File: rtl/refdiv_pd_top.sv
module refdiv_pd_top
  import refdiv_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int MIN_RATIO = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_ratio_i,
  input  logic             sense_pos_i,
  input  logic             pump_hiz_i,
  input  logic             test_mode_i,
  input  logic             n_pulse_i,
  output logic             ref_pulse_o,
  output logic             pump_up_o,
  output logic             pump_dn_o,
  output logic             pump_oe_o
);
  phase_t flags;
  pump_t  pump;
  logic   ref_ev;

  refdiv_counter #(.CNT_W(CNT_W), .MIN_RATIO(MIN_RATIO)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ratio_i (div_ratio_i),
    .pulse_o (ref_ev)
  );

  refdiv_pfd u_pfd (
    .clk      (clk),
    .rst      (rst),
    .ref_ev_i (ref_ev),
    .n_ev_i   (n_pulse_i),
    .clear_i  (pump_hiz_i),
    .flags_o  (flags)
  );

  refdiv_outmux u_mux (
    .clk      (clk),
    .rst      (rst),
    .flags_i  (flags),
    .ref_ev_i (ref_ev),
    .n_ev_i   (n_pulse_i),
    .test_i   (test_mode_i),
    .pos_i    (sense_pos_i),
    .hiz_i    (pump_hiz_i),
    .pump_o   (pump)
  );

  always_comb begin
    ref_pulse_o = ref_ev;
    pump_up_o   = pump.up;
    pump_dn_o   = pump.dn;
    pump_oe_o   = pump.oe;
  end
endmodule

// File: tb/refdiv_pd_top_tb_top.sv
module refdiv_pd_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] div_ratio = 10'd5;
  logic       sense_pos = 1'b1;
  logic       pump_hiz  = 1'b0;
  logic       test_mode = 1'b0;
  logic       n_pulse   = 1'b0;
  logic       ref_pulse, pump_up, pump_dn, pump_oe;

  int    checks = 0;
  int    errors = 0;
  int    nper   = 0;
  int    n_cnt  = 0;
  bit    run    = 1'b0;
  bit    done   = 1'b0;
  string ref_tag = "R2";

  // behavioural model state
  int m_cnt = 0;
  bit m_ref = 0, m_fu = 0, m_fd = 0, m_up = 0, m_dn = 0, m_oe = 0;

  always #4 clk = ~clk;

  refdiv_pd_top dut_i (
    .clk(clk), .rst(rst), .div_ratio_i(div_ratio), .sense_pos_i(sense_pos),
    .pump_hiz_i(pump_hiz), .test_mode_i(test_mode), .n_pulse_i(n_pulse),
    .ref_pulse_o(ref_pulse), .pump_up_o(pump_up), .pump_dn_o(pump_dn),
    .pump_oe_o(pump_oe)
  );

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // Reference model, evaluated from the values present before each edge.
  always @(posedge clk) begin
    int eff, ncnt;
    bit nref, u, d, nu, nd, po, pu, pd;
    if (rst) begin
      m_cnt = 0; m_ref = 0; m_fu = 0; m_fd = 0; m_up = 0; m_dn = 0; m_oe = 0;
    end else begin
      eff  = (int'(div_ratio) < 2) ? 2 : int'(div_ratio);
      nref = (m_cnt == 0);
      ncnt = nref ? eff - 1 : m_cnt - 1;
      u = m_fu | m_ref;
      d = m_fd | n_pulse;
      if (pump_hiz || (u && d)) begin nu = 0; nd = 0; end
      else begin nu = u; nd = d; end
      if (test_mode) begin
        po = 1; pd = 0; pu = sense_pos ? n_pulse : m_ref;
      end else if (pump_hiz) begin
        po = 0; pu = 0; pd = 0;
      end else begin
        po = 1;
        pu = sense_pos ? m_fu : m_fd;
        pd = sense_pos ? m_fd : m_fu;
      end
      m_cnt = ncnt; m_ref = nref; m_fu = nu; m_fd = nd;
      m_up = pu; m_dn = pd; m_oe = po;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    string ptag;
    if (run) begin
      ptag = test_mode ? "R8" : pump_hiz ? "R7" : sense_pos ? "R5" : "R6";
      chk(ref_tag, "ref_pulse", ref_pulse, m_ref);
      chk(ptag, "pump_up", pump_up, m_up);
      chk(ptag, "pump_dn", pump_dn, m_dn);
      chk(ptag, "pump_oe", pump_oe, m_oe);
    end
  end

  // Feedback-pulse generator.
  always @(negedge clk) begin
    if (nper > 0) begin
      n_pulse <= (n_cnt == 0);
      n_cnt   <= (n_cnt == 0) ? nper - 1 : n_cnt - 1;
    end else begin
      n_pulse <= 1'b0;
    end
  end

  task automatic phase(input int ratio, input bit pos, input bit hiz, input bit tst,
                       input int np, input int cycles, input string tag);
    @(negedge clk);
    div_ratio = 10'(ratio);
    sense_pos = pos; pump_hiz = hiz; test_mode = tst;
    nper = np; ref_tag = tag;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ref_pulse", ref_pulse, 1'b0);
    chk("R1", "pump_up", pump_up, 1'b0);
    chk("R1", "pump_dn", pump_dn, 1'b0);
    chk("R1", "pump_oe", pump_oe, 1'b0);
    rst = 1'b0;
    run = 1'b1;
    phase(5, 1, 0, 0, 5, 60, "R2");      // locked-frequency case
    phase(5, 1, 0, 0, 6, 80, "R2");      // drifting phase, lead and lag
    phase(3, 1, 0, 0, 4, 60, "R4");      // ratio change mid-count
    phase(1, 1, 0, 0, 3, 40, "R3");      // prohibited ratio 1
    phase(0, 1, 0, 0, 3, 40, "R3");      // prohibited ratio 0
    phase(7, 0, 0, 0, 8, 100, "R2");     // negative sense
    phase(7, 0, 0, 0, 6, 60, "R2");
    phase(6, 1, 1, 0, 4, 50, "R2");      // high impedance
    phase(6, 1, 0, 0, 4, 30, "R2");
    phase(4, 1, 1, 1, 3, 50, "R2");      // test: feedback observed
    phase(4, 0, 1, 1, 3, 50, "R2");      // test: reference observed
    phase(4, 1, 0, 0, 0, 40, "R2");      // reference events only
    phase(1023, 1, 0, 0, 1000, 2500, "R2");
    run = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule